// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block judges the 48-bit destination address of each received frame and returns an accept or reject verdict on the clock edge after the address is presented. It combines three mechanisms. A bank of eight exact-match slots holds station and multicast addresses. A 64-bit multicast hash table is indexed by a 6-bit fold of the address. Two mode bits act as overrides: one accepts every frame, the other accepts every multicast frame. A separate enable governs broadcast.

All tables and modes are loaded through a single-cycle write port. Software programs the exact slots and the hash words there and sets how many slots are reserved for unicast station addresses. A combinational helper output returns the 6-bit hash of any address placed on a probe input, so software can find which table bit to set. Address octet 0, the first one on the wire, sits in `da[7:0]`. Octet k sits in `da[8k+7:8k]`. Bit 0 of octet 0, which is `da[0]`, is the group (multicast) bit.

Top module: `rx_addr_filter`

## Requirements
- R1: `probe_hash` is the 6-bit fold of `probe_addr`. The address is read as a 48-bit stream, octet 0 first and each octet least significant bit first, and stream bit k is XORed into hash bit (k mod 6).
- R2: Configuration word 16 is the low table word and word 17 is the high word. A non-broadcast multicast address whose hash h is below 32 is accepted when bit h of word 16 is set. For h from 32 to 63 the address is accepted when bit h-32 of word 17 is set.
- R3: Exact slot i has a low word at configuration address 2i, holding octets 3,2,1,0 with octet 3 in bits 31:24. It has a high word at address 2i+1, holding octet 5 in bits 15:8 and octet 4 in bits 7:0. A valid slot whose stored address equals `da` and whose role fits the address (see R5) causes acceptance.
- R4: A write to the low word of a slot disables that slot. A later write to its high word enables it again. A disabled slot never matches.
- R5: Control word 18, bits 7:4, holds N, the number of slots reserved for unicast. Slots below N match only unicast addresses, and slots from N upward match only multicast addresses. A write with N greater than 8 leaves N unchanged.
- R6: A unicast address (`da[0]`=0) is accepted only through an exact-slot hit, or through promiscuous mode. The hash table never accepts a unicast address.
- R7: With control bit 0 (promiscuous) set, every presented address is accepted.
- R8: With control bit 1 (all-multicast) set, every non-broadcast multicast address is accepted whatever the hash table holds.
- R9: The all-ones address is accepted if and only if control bit 2 (broadcast enable) or promiscuous mode is set. The exact slots, the hash table and all-multicast mode do not affect it.
- R10: After reset, the outputs are low, all slots are invalid, the table is zero, promiscuous and all-multicast are off, broadcast enable is on and N is 1.
- R11: `res_valid` follows `da_valid` by one cycle. `res_accept` is low whenever `res_valid` is low. A configuration write made in the same cycle as a lookup does not affect that lookup's verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address valid |
| da | input | 48 | Destination address, octet 0 in bits 7:0 |
| probe_addr | input | 48 | Address for the hash helper |
| probe_hash | output | 6 | Hash of `probe_addr` |
| res_valid | output | 1 | Verdict valid, one cycle after `da_valid` |
| res_accept | output | 1 | Frame accepted |

## Verification
The hardest situation to reach is a slot that is half rewritten. Its low word holds a new value while its high word still holds the old one, so the old address must now miss even though most of its bits still sit in storage. The stimulus programs a slot, hits it, rewrites only the low word with the same value, looks up the old address, and only then writes the high word. The reservation boundary is also hard to reach. A unicast address is placed in a slot at or above N, and a later write with N above eight must not move the boundary. The stimulus then checks that this address is still rejected.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
    localparam int AF_DW     = 32;
    localparam int AF_ADDR_W = 48;

    typedef struct packed {
        logic promisc;
        logic allmulti;
        logic bcast_en;
    } af_mode_t;
endpackage

// File: rtl/afilt_hash.sv
module afilt_hash #(
    parameter int ADDR_W = 48,
    parameter int HASH_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [HASH_W-1:0] hash
);
    function automatic logic [ADDR_W-1:0] fold_mask(input int j);
        logic [ADDR_W-1:0] m;
        m = '0;
        for (int k = 0; k < ADDR_W; k++)
            if ((k % HASH_W) == j) m[k] = 1'b1;
        return m;
    endfunction

    for (genvar j = 0; j < HASH_W; j++) begin : g_fold
        localparam logic [ADDR_W-1:0] MASK = fold_mask(j);
        assign hash[j] = ^(addr & MASK);
    end
endmodule

// File: rtl/afilt_exact.sv
module afilt_exact import afilt_pkg::*; #(
    parameter  int NUM_EXACT = 8,
    parameter  int ADDR_W    = 48,
    localparam int IDXW      = $clog2(NUM_EXACT),
    localparam int NUCW      = $clog2(NUM_EXACT + 1),
    localparam int HIW       = ADDR_W - AF_DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDXW-1:0]      wr_idx,
    input  logic                 wr_hi,
    input  logic [AF_DW-1:0]     wr_data,
    input  logic [NUCW-1:0]      n_ucast,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_EXACT-1:0] hit_vec
);
    typedef struct packed {
        logic             valid;
        logic [HIW-1:0]   hi;
        logic [AF_DW-1:0] lo;
    } entry_t;

    entry_t [NUM_EXACT-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (wr_en) begin
            if (wr_hi) begin
                ent_d[wr_idx].hi    = wr_data[HIW-1:0];
                ent_d[wr_idx].valid = 1'b1;
            end else begin
                ent_d[wr_idx].lo    = wr_data;
                ent_d[wr_idx].valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    always_comb begin
        for (int i = 0; i < NUM_EXACT; i++) begin
            hit_vec[i] = ent_q[i].valid
                      && ({ent_q[i].hi, ent_q[i].lo} == addr)
                      && ((i < int'(n_ucast)) ? !addr[0] : addr[0]);
        end
    end

    for (genvar i = 0; i < NUM_EXACT; i++) begin : g_chk
        AST_LOW_WRITE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && !wr_hi && (int'(wr_idx) == i) |=> !hit_vec[i]); // R4
        AST_HIGH_WRITE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_hi && (int'(wr_idx) == i) |=> ent_q[i].valid); // R4
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter import afilt_pkg::*; #(
    parameter  int NUM_EXACT = 8,
    parameter  int HASH_W    = 6,
    localparam int TBL_BITS  = 2 ** HASH_W,
    localparam int TBL_WORDS = TBL_BITS / AF_DW,
    localparam int HASH_BASE = 2 * NUM_EXACT,
    localparam int CTRL_ADDR = HASH_BASE + TBL_WORDS,
    localparam int CFG_AW    = $clog2(CTRL_ADDR + 1),
    localparam int IDXW      = $clog2(NUM_EXACT),
    localparam int NUCW      = $clog2(NUM_EXACT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [AF_DW-1:0]     cfg_wdata,
    input  logic                 da_valid,
    input  logic [AF_ADDR_W-1:0] da,
    input  logic [AF_ADDR_W-1:0] probe_addr,
    output logic [HASH_W-1:0]    probe_hash,
    output logic                 res_valid,
    output logic                 res_accept
);
    typedef struct packed {
        af_mode_t            mode;
        logic [NUCW-1:0]     n_ucast;
        logic [TBL_BITS-1:0] tbl;
        logic                res_valid;
        logic                res_accept;
    } state_t;

    state_t st_d, st_q;

    logic [HASH_W-1:0]    look_hash;
    logic [NUM_EXACT-1:0] hit_vec;
    logic                 ent_wr;
    logic                 exact_hit;
    logic                 is_bcast;
    logic                 is_mc;
    logic                 verdict;

    afilt_hash #(.ADDR_W(AF_ADDR_W), .HASH_W(HASH_W)) u_look_hash (
        .addr (da),
        .hash (look_hash)
    );

    afilt_hash #(.ADDR_W(AF_ADDR_W), .HASH_W(HASH_W)) u_probe_hash (
        .addr (probe_addr),
        .hash (probe_hash)
    );

    assign ent_wr = cfg_we && (int'(cfg_addr) < HASH_BASE);

    afilt_exact #(.NUM_EXACT(NUM_EXACT), .ADDR_W(AF_ADDR_W)) u_exact (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ent_wr),
        .wr_idx  (cfg_addr[1 +: IDXW]),
        .wr_hi   (cfg_addr[0]),
        .wr_data (cfg_wdata),
        .n_ucast (st_q.n_ucast),
        .addr    (da),
        .hit_vec (hit_vec)
    );

    assign exact_hit = |hit_vec;
    assign is_bcast  = &da;
    assign is_mc     = da[0];

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            for (int w = 0; w < TBL_WORDS; w++)
                if (int'(cfg_addr) == HASH_BASE + w)
                    st_d.tbl[AF_DW*w +: AF_DW] = cfg_wdata;
            if (int'(cfg_addr) == CTRL_ADDR) begin
                st_d.mode.promisc  = cfg_wdata[0];
                st_d.mode.allmulti = cfg_wdata[1];
                st_d.mode.bcast_en = cfg_wdata[2];
                if (int'(cfg_wdata[4 +: NUCW]) <= NUM_EXACT)
                    st_d.n_ucast = cfg_wdata[4 +: NUCW];
            end
        end
        if (st_q.mode.promisc)
            verdict = 1'b1;
        else if (is_bcast)
            verdict = st_q.mode.bcast_en;
        else
            verdict = exact_hit
                   || (is_mc && (st_q.mode.allmulti || st_q.tbl[look_hash]));
        st_d.res_valid  = da_valid;
        st_d.res_accept = da_valid && verdict;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q               <= '0;
            st_q.mode.bcast_en <= 1'b1;
            st_q.n_ucast       <= NUCW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid  = st_q.res_valid;
    assign res_accept = st_q.res_accept;

    AST_PROMISC_TAKES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid && st_q.mode.promisc |=> res_accept); // R7
    AST_UCAST_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid && !da[0] && !st_q.mode.promisc && !exact_hit |=> !res_accept); // R6
    AST_ALLMULTI_TAKES_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid && da[0] && !is_bcast && st_q.mode.allmulti |=> res_accept); // R8
    AST_BCAST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid && is_bcast && !st_q.mode.promisc && !st_q.mode.bcast_en |=> !res_accept); // R9
    AST_IDLE_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_accept); // R11
    AST_UCAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.n_ucast) <= NUM_EXACT); // R5
endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic [47:0] probe_addr = '0;
    logic [5:0]  probe_hash;
    logic        res_valid, res_accept;

    always #2 clk = ~clk;

    rx_addr_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
        .probe_addr(probe_addr), .probe_hash(probe_hash),
        .res_valid(res_valid), .res_accept(res_accept)
    );

    int checks = 0;
    int fails  = 0;
    string cur_req = "R10";

    logic [31:0] m_lo [8];
    logic [15:0] m_hi [8];
    bit          m_v  [8];
    logic [63:0] m_tbl;
    bit m_prom, m_allm, m_bc;
    int m_n;

    function automatic logic [5:0] ref_hash(logic [47:0] a);
        logic [5:0] h = '0;
        int pos = 0;
        for (int o = 0; o < 6; o++)
            for (int b = 0; b < 8; b++) begin
                h[pos] = h[pos] ^ a[8*o + b];
                pos = (pos == 5) ? 0 : pos + 1;
            end
        return h;
    endfunction

    function automatic bit ref_accept(logic [47:0] a);
        bit grp = a[0];
        if (m_prom) return 1'b1;
        if (a == {48{1'b1}}) return m_bc;
        for (int i = 0; i < 8; i++)
            if (m_v[i] && {m_hi[i], m_lo[i]} == a && ((i < m_n) ? !grp : grp))
                return 1'b1;
        if (grp && (m_allm || m_tbl[ref_hash(a)])) return 1'b1;
        return 1'b0;
    endfunction

    task automatic ref_write(int ad, logic [31:0] wd);
        if (ad < 16) begin
            if (ad % 2 == 1) begin m_hi[ad/2] = wd[15:0]; m_v[ad/2] = 1'b1; end
            else begin m_lo[ad/2] = wd; m_v[ad/2] = 1'b0; end
        end else if (ad == 16) m_tbl[31:0] = wd;
        else if (ad == 17) m_tbl[63:32] = wd;
        else if (ad == 18) begin
            m_prom = wd[0]; m_allm = wd[1]; m_bc = wd[2];
            if (int'(wd[7:4]) <= 8) m_n = int'(wd[7:4]);
        end
    endtask

    task automatic check(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic step(bit v, logic [47:0] a, bit we, int ad, logic [31:0] wd);
        bit ev, ea;
        @(negedge clk);
        da_valid = v; da = a; probe_addr = a;
        cfg_we = we; cfg_addr = 5'(ad); cfg_wdata = wd;
        #1;
        begin
            string keep = cur_req;
            cur_req = "R1";
            check("probe_hash", 64'(probe_hash), 64'(ref_hash(a)));
            cur_req = keep;
        end
        ev = v;
        ea = v ? ref_accept(a) : 1'b0;
        if (we) ref_write(ad, wd);
        @(posedge clk);
        #1;
        check("res_valid", 64'(res_valid), 64'(ev));
        check("res_accept", 64'(res_accept), 64'(ea));
        da_valid = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic wr(int ad, logic [31:0] wd);
        step(1'b0, 48'h0, 1'b1, ad, wd);
    endtask

    task automatic look(logic [47:0] a);
        step(1'b1, a, 1'b0, 0, 32'h0);
    endtask

    task automatic set_slot(int i, logic [47:0] a);
        wr(2*i, a[31:0]);
        wr(2*i + 1, {16'h0, a[47:32]});
    endtask

    localparam logic [47:0] UC_A = 48'h6655_4433_2210;
    localparam logic [47:0] UC_B = 48'h0a0b_0c0d_0e02;
    localparam logic [47:0] UC_C = 48'h1234_5678_9a04;
    localparam logic [47:0] MC_M = 48'h00aa_bbcc_dd01;
    localparam logic [47:0] BC   = {48{1'b1}};

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_v[i] = 1'b0; end
        m_tbl = '0; m_prom = 0; m_allm = 0; m_bc = 1; m_n = 1;

        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        cur_req = "R10";
        check("res_valid at reset", 64'(res_valid), 64'h0);
        check("res_accept at reset", 64'(res_accept), 64'h0);
        rst_n = 1'b1;
        look(UC_A);
        look(MC_M);
        look(48'h0);

        // R1: hash probe over varied patterns
        cur_req = "R1";
        look(48'h0000_0000_0001);
        look(48'h0000_0000_0021);
        look(48'h8000_0000_0000);
        look(48'hdead_beef_cafe);

        // R9: broadcast on by default
        cur_req = "R9";
        look(BC);

        // R3: exact slot 0 as station address
        cur_req = "R3";
        set_slot(0, UC_A);
        look(UC_A);
        look(UC_A ^ 48'h0100_0000_0000);
        look(UC_A ^ 48'h0000_8000_0000);

        // R4: low rewrite disables until high written
        cur_req = "R4";
        wr(0, UC_A[31:0]);
        look(UC_A);
        wr(1, {16'h0, UC_A[47:32]});
        look(UC_A);

        // R5: reservation boundary
        cur_req = "R5";
        wr(18, 32'h0000_0024);
        set_slot(1, UC_B);
        look(UC_B);
        set_slot(3, MC_M);
        look(MC_M);
        set_slot(4, UC_C);
        look(UC_C);
        set_slot(2, MC_M ^ 48'h0000_0000_0100);
        look(MC_M ^ 48'h0000_0000_0100);
        wr(18, 32'h0000_0094);
        look(UC_C);
        look(UC_B);

        // R2: hash table, low and high words
        cur_req = "R2";
        look(48'h0000_0000_0021);
        wr(17, 32'h0000_0002);
        look(48'h0000_0000_0021);
        look(48'h0000_0000_0001);
        wr(16, 32'h0000_0002);
        look(48'h0000_0000_0001);
        look(48'h0000_0000_0041);
        wr(16, 32'h0000_0000);
        look(48'h0000_0000_0001);

        // R6: unicast never via hash
        cur_req = "R6";
        wr(16, 32'hffff_ffff);
        wr(17, 32'hffff_ffff);
        look(UC_C ^ 48'h10);
        look(48'h0000_0000_0000);
        wr(16, 32'h0);
        wr(17, 32'h0);

        // R8: all-multicast
        cur_req = "R8";
        wr(18, 32'h0000_0026);
        look(48'h0123_4567_89ab);
        look(UC_C ^ 48'h10);

        // R9: broadcast disabled ignores allmulti and hash
        cur_req = "R9";
        wr(16, 32'hffff_ffff);
        wr(17, 32'hffff_ffff);
        wr(18, 32'h0000_0022);
        look(BC);
        wr(18, 32'h0000_0024);
        look(BC);

        // R7: promiscuous
        cur_req = "R7";
        wr(18, 32'h0000_0021);
        look(BC);
        look(48'h7777_7777_7770);
        look(48'h0123_4567_89ab);

        // R11: write in same cycle as lookup, idle cycles
        cur_req = "R11";
        wr(18, 32'h0000_0020);
        step(1'b1, 48'h1111_2222_3330, 1'b1, 18, 32'h0000_0021);
        look(48'h1111_2222_3330);
        step(1'b0, 48'h1111_2222_3330, 1'b0, 0, 32'h0);
        step(1'b1, UC_B, 1'b1, 2, 32'h0);
        look(UC_B);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule